// File: doc/BRIEF.md
# Power-Down Mode Controller

This block turns a power-down request, written by the CPU as a 6-bit field inside a control word, into the clock-control signals that put the chip into one of three sleep depths. It also decides when each depth ends. The light depth gates only the CPU clock. Interrupt logic and DMA traffic keep running. It ends on an interrupt, and two variants of the light depth use different interrupt rules. The two deeper depths halt the PLL output, or also stop the PLL reference input. Both keep all state and hold pins at their last values, and only a reset ends them.

After a reset that ends the deepest depth, the PLL must relock as it does at power-up. The controller holds a relock-busy flag for a parameterised number of reference cycles. The CPU clock stays gated for that whole time. When an interrupt ends the light depth, a one-cycle wake pulse is issued. A flag issued with it tells the core whether to enter the service routine or simply resume.

Top module: `pd_ctrl`

## Requirements
- R1: After a reset that does not end the deepest depth, `mode_rd` is 000000 and every clock-control output, `wake_pulse`, `isr_entry` and `relock_busy` are low.
- R2: A write while running takes effect at the clock edge that samples `wr_en`. The field is `wr_data[15:10]`: 001001 selects light sleep woken by an enabled interrupt, 010001 selects light sleep woken by any interrupt, 011010 selects halt and 011100 selects deep stop. `mode_rd` returns the accepted code.
- R3: Any other code in the field, including 000000, is ignored. The chip keeps running, `mode_rd` reads 000000, and the other bits of the word have no effect.
- R4: In either light sleep, `cpu_clk_gate` is high while `pll_out_halt` and `pll_in_stop` are low.
- R5: Light sleep with code 001001 ends only when some line has both `irq_pend` and `irq_en` set. A pending line whose enable is clear leaves the mode in place.
- R6: Light sleep with code 010001 ends on any pending line, whatever `irq_en` holds.
- R7: A wake raises `wake_pulse` for exactly one cycle. In the same cycle `mode_rd` returns to 000000 and `cpu_clk_gate` drops.
- R8: `isr_entry` is high in the wake cycle only if `gie` and `nmie` are both set. Otherwise it stays low.
- R9: Halt drives `cpu_clk_gate` and `pll_out_halt` high. Interrupts do not end it. A reset ends it without any relock wait.
- R10: Deep stop drives `cpu_clk_gate`, `pll_out_halt` and `pll_in_stop` high. Interrupts do not end it. After the reset that ends it, `relock_busy` stays high for RELOCK_CYCLES cycles following reset release, and `cpu_clk_gate` stays high as long as `relock_busy` is high.
- R11: A write is ignored while a sleep mode is active or while `relock_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset; the only exit from halt and deep stop |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | DATA_W | Control word; mode field at bits 15:10 |
| irq_pend | input | NIRQ | Pending interrupt lines |
| irq_en | input | NIRQ | Per-line interrupt enable mask |
| gie | input | 1 | Global interrupt enable |
| nmie | input | 1 | Non-maskable interrupt enable |
| mode_rd | output | 6 | Code of the active mode, 000000 when running |
| cpu_clk_gate | output | 1 | High stops the CPU clock at its boundary |
| pll_out_halt | output | 1 | High halts the PLL output clock |
| pll_in_stop | output | 1 | High stops the PLL reference input |
| wake_pulse | output | 1 | One-cycle pulse when light sleep ends |
| isr_entry | output | 1 | With wake_pulse: enter the service routine instead of resuming |
| relock_busy | output | 1 | PLL relock wait after leaving deep stop |

## Verification
A mode write, an interrupt wake and its `isr_entry` flag each appear one register stage later. They are all visible at the first falling edge after the rising edge that sampled the stimulus. The bench drives every input on a falling edge, steps exactly one rising edge, and reads the outputs on the next falling edge. `relock_busy` reads high at the falling edge of reset release and then for RELOCK_CYCLES-1 more falling edges. The bench counts those samples and compares the count with the parameter.

// File: rtl/pd_ctrl_pkg.sv
package pd_ctrl_pkg;

    localparam int CODE_W = 6;

    localparam logic [CODE_W-1:0] CODE_RUN      = 6'b000000;
    localparam logic [CODE_W-1:0] CODE_LITE_EN  = 6'b001001;
    localparam logic [CODE_W-1:0] CODE_LITE_ANY = 6'b010001;
    localparam logic [CODE_W-1:0] CODE_HALT     = 6'b011010;
    localparam logic [CODE_W-1:0] CODE_DEEP     = 6'b011100;

    typedef enum logic [2:0] {
        PM_RUN,
        PM_LITE_EN,
        PM_LITE_ANY,
        PM_HALT,
        PM_DEEP
    } pmode_t;

    typedef struct packed {
        logic cpu_gate;
        logic pll_halt;
        logic pll_stop;
    } clkctl_t;

    typedef struct packed {
        logic   valid;
        pmode_t mode;
    } pd_req_t;

    function automatic logic code_valid(logic [CODE_W-1:0] c);
        return (c == CODE_LITE_EN) || (c == CODE_LITE_ANY) ||
               (c == CODE_HALT)    || (c == CODE_DEEP);
    endfunction

    function automatic pmode_t code_to_mode(logic [CODE_W-1:0] c);
        pmode_t m;
        case (c)
            CODE_LITE_EN:  m = PM_LITE_EN;
            CODE_LITE_ANY: m = PM_LITE_ANY;
            CODE_HALT:     m = PM_HALT;
            CODE_DEEP:     m = PM_DEEP;
            default:       m = PM_RUN;
        endcase
        return m;
    endfunction

    function automatic logic [CODE_W-1:0] mode_to_code(pmode_t m);
        logic [CODE_W-1:0] c;
        case (m)
            PM_LITE_EN:  c = CODE_LITE_EN;
            PM_LITE_ANY: c = CODE_LITE_ANY;
            PM_HALT:     c = CODE_HALT;
            PM_DEEP:     c = CODE_DEEP;
            default:     c = CODE_RUN;
        endcase
        return c;
    endfunction

    function automatic clkctl_t mode_clocks(pmode_t m);
        clkctl_t k;
        k.cpu_gate = (m != PM_RUN);
        k.pll_halt = (m == PM_HALT) || (m == PM_DEEP);
        k.pll_stop = (m == PM_DEEP);
        return k;
    endfunction

    function automatic logic is_lite(pmode_t m);
        return (m == PM_LITE_EN) || (m == PM_LITE_ANY);
    endfunction

endpackage

// File: rtl/pd_req_decode.sv
module pd_req_decode
    import pd_ctrl_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int FIELD_LSB = 10
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output pd_req_t           req
);
    localparam int FIELD_MSB = FIELD_LSB + CODE_W - 1;

    logic [CODE_W-1:0] field;
    logic              unused_bits;

    assign field = wr_data[FIELD_MSB:FIELD_LSB];

    generate
        if (FIELD_LSB > 0 && FIELD_MSB < DATA_W - 1) begin : g_both
            assign unused_bits = ^{wr_data[DATA_W-1:FIELD_MSB+1], wr_data[FIELD_LSB-1:0]};
        end else if (FIELD_LSB > 0) begin : g_low
            assign unused_bits = ^wr_data[FIELD_LSB-1:0];
        end else if (FIELD_MSB < DATA_W - 1) begin : g_high
            assign unused_bits = ^wr_data[DATA_W-1:FIELD_MSB+1];
        end else begin : g_none
            assign unused_bits = 1'b0;
        end
    endgenerate

    always_comb begin
        req.valid = wr_en;
        req.mode  = code_to_mode(field);
    end
endmodule

// File: rtl/pd_wake_eval.sv
module pd_wake_eval
    import pd_ctrl_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  pmode_t            mode,
    input  logic [NIRQ-1:0]   irq_pend,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              gie,
    input  logic              nmie,
    output logic              wake,
    output logic              isr
);
    logic [NIRQ-1:0] masked;

    genvar i;
    generate
        for (i = 0; i < NIRQ; i++) begin : g_line
            assign masked[i] = irq_pend[i] & irq_en[i];
        end
    endgenerate

    always_comb begin
        case (mode)
            PM_LITE_EN:  wake = |masked;
            PM_LITE_ANY: wake = |irq_pend;
            default:     wake = 1'b0;
        endcase
        isr = wake & gie & nmie;
    end
endmodule

// File: rtl/pd_relock.sv
module pd_relock #(
    parameter int RELOCK_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic deep_now,
    output logic busy
);
    localparam int CW = $clog2(RELOCK_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(RELOCK_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            if (deep_now || cnt != '0) begin
                cnt <= LOAD;
            end else begin
                cnt <= '0;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/pd_ctrl.sv
module pd_ctrl
    import pd_ctrl_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int NIRQ          = 4,
    parameter int RELOCK_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NIRQ-1:0]   irq_pend,
    input  logic [NIRQ-1:0]   irq_en,
    input  logic              gie,
    input  logic              nmie,
    output logic [5:0]        mode_rd,
    output logic              cpu_clk_gate,
    output logic              pll_out_halt,
    output logic              pll_in_stop,
    output logic              wake_pulse,
    output logic              isr_entry,
    output logic              relock_busy
);
    localparam int FIELD_LSB = 10;

    pmode_t  mode_q;
    pd_req_t req;
    clkctl_t clk_sel;
    logic    wake_now;
    logic    isr_now;
    logic    wake_q;
    logic    isr_q;
    logic    busy;

    pd_req_decode #(.DATA_W(DATA_W), .FIELD_LSB(FIELD_LSB)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req     (req)
    );

    pd_wake_eval #(.NIRQ(NIRQ)) u_wake (
        .mode     (mode_q),
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .gie      (gie),
        .nmie     (nmie),
        .wake     (wake_now),
        .isr      (isr_now)
    );

    pd_relock #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_relock (
        .clk      (clk),
        .rst      (rst),
        .deep_now (mode_q == PM_DEEP),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_RUN;
            wake_q <= 1'b0;
            isr_q  <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            isr_q  <= 1'b0;
            if (is_lite(mode_q) && wake_now) begin
                mode_q <= PM_RUN;
                wake_q <= 1'b1;
                isr_q  <= isr_now;
            end else if (req.valid && mode_q == PM_RUN && !busy) begin
                mode_q <= req.mode;
            end
        end
    end

    always_comb begin
        clk_sel      = mode_clocks(mode_q);
        mode_rd      = mode_to_code(mode_q);
        cpu_clk_gate = clk_sel.cpu_gate | busy;
        pll_out_halt = clk_sel.pll_halt;
        pll_in_stop  = clk_sel.pll_stop;
        wake_pulse   = wake_q;
        isr_entry    = isr_q;
        relock_busy  = busy;
    end
endmodule

// File: rtl/pd_ctrl_chk.sv
module pd_ctrl_chk
    import pd_ctrl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [5:0]        mode_rd,
    input logic              cpu_clk_gate,
    input logic              pll_out_halt,
    input logic              pll_in_stop,
    input logic              wake_pulse,
    input logic              isr_entry,
    input logic              relock_busy
);
    // R3: a reserved code written while running leaves the chip running
    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode_rd == CODE_RUN && !relock_busy && !code_valid(wr_data[15:10]))
        |=> (mode_rd == CODE_RUN && !cpu_clk_gate));

    // R7: wake pulse lasts one cycle and lands in running mode
    a_r7_wake_single: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    a_r7_wake_running: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (mode_rd == CODE_RUN && !cpu_clk_gate));

    // R8: service-routine flag only alongside a wake
    a_r8_isr_with_wake: assert property (@(posedge clk) disable iff (rst)
        isr_entry |-> wake_pulse);

    // R9: halt persists until reset
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode_rd == CODE_HALT) |=> (mode_rd == CODE_HALT));

    // R10: deep stop persists until reset, and relock keeps the CPU clock gated
    a_r10_deep_sticky: assert property (@(posedge clk) disable iff (rst)
        (mode_rd == CODE_DEEP) |=> (mode_rd == CODE_DEEP && pll_in_stop && pll_out_halt));
    a_r10_relock_gates: assert property (@(posedge clk) disable iff (rst)
        relock_busy |-> (cpu_clk_gate && mode_rd == CODE_RUN));

    // R11: no mode change from one sleep code to another sleep code
    a_r11_no_rewrite: assert property (@(posedge clk) disable iff (rst)
        (mode_rd != CODE_RUN) |=> (mode_rd == CODE_RUN || $stable(mode_rd)));
endmodule

bind pd_ctrl pd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .mode_rd      (mode_rd),
    .cpu_clk_gate (cpu_clk_gate),
    .pll_out_halt (pll_out_halt),
    .pll_in_stop  (pll_in_stop),
    .wake_pulse   (wake_pulse),
    .isr_entry    (isr_entry),
    .relock_busy  (relock_busy)
);

// File: tb/sim_pd_ctrl.sv
`timescale 1ns/1ps
module sim_pd_ctrl;
    localparam int DW     = 16;
    localparam int NIRQ   = 4;
    localparam int RELOCK = 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en;
    logic [DW-1:0]   wr_data;
    logic [NIRQ-1:0] irq_pend;
    logic [NIRQ-1:0] irq_en;
    logic            gie;
    logic            nmie;
    logic [5:0]      mode_rd;
    logic            cpu_clk_gate;
    logic            pll_out_halt;
    logic            pll_in_stop;
    logic            wake_pulse;
    logic            isr_entry;
    logic            relock_busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pd_ctrl #(.DATA_W(DW), .NIRQ(NIRQ), .RELOCK_CYCLES(RELOCK)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .irq_pend(irq_pend), .irq_en(irq_en), .gie(gie), .nmie(nmie),
        .mode_rd(mode_rd), .cpu_clk_gate(cpu_clk_gate),
        .pll_out_halt(pll_out_halt), .pll_in_stop(pll_in_stop),
        .wake_pulse(wake_pulse), .isr_entry(isr_entry), .relock_busy(relock_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit is_valid(input logic [5:0] c);
        return (c == 6'b001001) || (c == 6'b010001) || (c == 6'b011010) || (c == 6'b011100);
    endfunction

    task automatic write_code(input logic [5:0] c, input int filler);
        wr_data = {c, 10'(filler)};
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic reset_pulse;
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic relock_measure(input int exp_len);
        int n = 0;
        while (relock_busy && n < 4 * RELOCK) begin
            check("R10 gate during relock", cpu_clk_gate, 1);
            n++;
            tick();
        end
        check("R10 relock length", n, exp_len);
        check("R10 gate after relock", cpu_clk_gate, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        irq_pend = '0; irq_en = '0; gie = 1'b0; nmie = 1'b0;
        @(negedge clk);
        tick(); tick(); tick();
        rst = 1'b0;

        // R1 reset state
        check("R1 mode", mode_rd, 0);
        check("R1 gate", cpu_clk_gate, 0);
        check("R1 halt", pll_out_halt, 0);
        check("R1 stop", pll_in_stop, 0);
        check("R1 wake", wake_pulse, 0);
        check("R1 isr", isr_entry, 0);
        check("R1 busy", relock_busy, 0);

        // R2/R3/R4/R9/R10 sweep over every code
        for (int c = 0; c < 64; c++) begin
            logic [5:0] code;
            bit v;
            code = 6'(c);
            v = is_valid(code);
            write_code(code, c * 37 + 5);
            if (v) begin
                check("R2 mode readback", mode_rd, code);
            end else begin
                check("R3 reserved readback", mode_rd, 0);
                check("R3 reserved gate", cpu_clk_gate, 0);
                check("R3 reserved no wake", wake_pulse, 0);
            end
            check("R2 gate", cpu_clk_gate, v);
            check("R4 R9 halt", pll_out_halt, (code == 6'b011010) || (code == 6'b011100));
            check("R10 stop", pll_in_stop, code == 6'b011100);
            if (code == 6'b001001 || code == 6'b010001) begin
                irq_pend = 4'h1; irq_en = 4'h1;
                tick();
                irq_pend = '0; irq_en = '0;
                check("R7 wake high", wake_pulse, 1);
                check("R7 mode cleared", mode_rd, 0);
                check("R7 gate released", cpu_clk_gate, 0);
                tick();
                check("R7 wake single", wake_pulse, 0);
            end else if (code == 6'b011010 || code == 6'b011100) begin
                irq_pend = '1; irq_en = '1; gie = 1'b1; nmie = 1'b1;
                tick(); tick(); tick();
                irq_pend = '0; irq_en = '0; gie = 1'b0; nmie = 1'b0;
                check("R9 R10 irq ignored mode", mode_rd, code);
                check("R9 R10 irq ignored wake", wake_pulse, 0);
                reset_pulse();
                check("R9 R10 reset exit mode", mode_rd, 0);
                if (code == 6'b011100) begin
                    relock_measure(RELOCK);
                end else begin
                    check("R9 no relock", relock_busy, 0);
                    check("R9 gate released", cpu_clk_gate, 0);
                end
            end
        end

        // R5/R6 mask sweep
        for (int vsel = 0; vsel < 2; vsel++) begin
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 16; e++) begin
                    logic [5:0] code;
                    bit exp_wake;
                    code = (vsel == 0) ? 6'b001001 : 6'b010001;
                    exp_wake = (vsel == 0) ? ((p & e) != 0) : (p != 0);
                    write_code(code, p * 16 + e);
                    irq_pend = 4'(p); irq_en = 4'(e);
                    tick();
                    irq_pend = '0; irq_en = '0;
                    check(vsel == 0 ? "R5 wake" : "R6 wake", wake_pulse, exp_wake);
                    check(vsel == 0 ? "R5 mode" : "R6 mode", mode_rd, exp_wake ? 6'd0 : code);
                    check("R4 gate in sleep", cpu_clk_gate, !exp_wake);
                    if (!exp_wake) begin
                        irq_pend = 4'h8; irq_en = 4'h8;
                        tick();
                        irq_pend = '0; irq_en = '0;
                    end
                    tick();
                end
            end
        end

        // R8 service-routine flag
        for (int vsel = 0; vsel < 2; vsel++) begin
            for (int g = 0; g < 2; g++) begin
                for (int n = 0; n < 2; n++) begin
                    gie = g[0]; nmie = n[0];
                    write_code(vsel == 0 ? 6'b001001 : 6'b010001, 0);
                    irq_pend = 4'h2; irq_en = 4'h2;
                    tick();
                    irq_pend = '0; irq_en = '0;
                    check("R8 wake", wake_pulse, 1);
                    check("R8 isr", isr_entry, g & n);
                    tick();
                    check("R8 isr drops", isr_entry, 0);
                end
            end
        end
        gie = 1'b0; nmie = 1'b0;

        // R11 writes during sleep and relock
        write_code(6'b001001, 0);
        write_code(6'b011100, 0);
        check("R11 write in sleep ignored", mode_rd, 6'b001001);
        check("R11 no deep stop", pll_in_stop, 0);
        irq_pend = 4'h4; irq_en = 4'h4;
        tick();
        irq_pend = '0; irq_en = '0;
        tick();
        write_code(6'b011100, 0);
        reset_pulse();
        write_code(6'b001001, 0);
        check("R11 write in relock ignored", mode_rd, 0);
        relock_measure(RELOCK - 1);
        check("R11 mode after relock", mode_rd, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule